// File: doc/BRIEF.md
# Host Indirect Memory Window

This peripheral lets an outside host reach a 32-bit wide internal RAM through six byte-wide registers. Two of them hold a word address and an access-mode code. The other four are data lanes that together form one little-endian word. The host sets the address once, then moves data through the lanes. The block turns those lane reads and writes into memory reads and writes, each with byte enables.

In the two 32-bit modes, the data passes through a staging register. Reading lane 0 fetches the addressed word. Writing lane 3 stores the whole staged word. One of these modes then steps the word address forward after each fetch or store, so the host can stream a block of words without reloading the address.

Two narrower modes exist for small transfers. In byte mode, each lane touches its own byte of memory directly. In halfword mode, the even lanes fetch and the odd lanes store a 16-bit half.

Top module: `hostwin_port`

## Requirements
- R1: Offset 0 is the low address register. Bits [7:2] hold byte-address bits [7:2] and bits [1:0] hold the mode code: 0 = byte, 1 = halfword, 2 = word, 3 = word with auto-increment. A read of offset 0 returns this value.
- R2: Offset 1 holds byte-address bits [14:8] in its bits [6:0]. Bit 7 of a written value is dropped, and this offset always reads back with bit 7 clear.
- R3: In modes 2 and 3, reading offset 2 (lane 0) fetches the addressed word with all four byte enables set. Offsets 2 to 5 then return its bytes 0 to 3. Reading offsets 3 to 5 never starts a memory access.
- R4: In modes 2 and 3, writes to offsets 2 to 4 only stage data. A write to offset 5 (lane 3) stores the whole staged word, with all byte enables set, at the current word address. This also holds when the host writes only some of the lanes.
- R5: In mode 3, the word address goes up by one word after every fetch and every store. In mode 2 it stays where it is.
- R6: The auto-increment wraps modulo the 15-bit byte-address space, so the word after byte address 0x7FFC is byte address 0.
- R7: In mode 0, a read or write of lane n accesses only byte n of the addressed word, with exactly one byte enable set. A write takes effect immediately.
- R8: In mode 1, reading lane 0 or 2 fetches the matching half with byte enables 0x3 or 0xC. Writing lane 1 or 3 stores that half, built from the staged even lane and the new odd byte, with the same enables.
- R9: A write to either address register clears any data already staged. A later store therefore writes zero into the lanes that were not rewritten.
- R10: Every host read is answered one cycle later, with read-valid high for exactly that cycle. After reset, both address registers read zero and read-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset (0..5 used) |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read answer, one cycle after host_rd |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | 13 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Fetch data, one cycle after request |

## Verification
The bench first checks unaligned use of the lanes. It reads lanes 1 to 3 without reading lane 0, and it writes only lanes 2 and 3. A design that triggered on the wrong lane would either make stray memory accesses or store stale bytes.

It also writes an address register in the middle of a staged write. A design that kept the old staged bytes would store them in place of zeros.

In auto-increment mode, the bench streams words and then reads the address back after the last word. It also fetches at the top of the address space. A design that stepped the address on the wrong event, or failed to wrap, would return the wrong word or a wrong address byte.

Byte and halfword accesses are read back in word mode. A wrong byte-enable pattern would show up there as a corrupted neighbouring byte.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    MODE_B8     = 2'd0,
    MODE_H16    = 2'd1,
    MODE_W32    = 2'd2,
    MODE_W32INC = 2'd3
  } mode_e;

  localparam logic [2:0] OFF_ALO   = 3'd0;
  localparam logic [2:0] OFF_AHI   = 3'd1;
  localparam logic [2:0] OFF_LANE0 = 3'd2;
  localparam logic [2:0] OFF_LANE3 = 3'd5;

  typedef struct packed {
    logic                 fetch;
    logic                 commit;
    logic                 stage_wr;
    logic                 inc;
    logic [LANES-1:0]     be;
  } mem_op_t;

endpackage

// File: rtl/hostwin_decode.sv
module hostwin_decode
  import hostwin_pkg::*;
(
  input  logic [2:0] host_addr,
  input  logic       host_rd,
  input  logic       host_wr,
  input  mode_e      mode,
  output logic       rd_act,
  output logic       is_lane,
  output logic [1:0] lane,
  output logic       alo_wr,
  output logic       ahi_wr,
  output mem_op_t    op
);

  logic [2:0] rel;
  logic       lane_rd;
  logic       lane_wr;

  always_comb begin
    rel     = host_addr - OFF_LANE0;
    lane    = rel[1:0];
    is_lane = (host_addr >= OFF_LANE0) && (host_addr <= OFF_LANE3);
    rd_act  = host_rd && !host_wr;
    lane_rd = rd_act && is_lane;
    lane_wr = host_wr && is_lane;
    alo_wr  = host_wr && (host_addr == OFF_ALO);
    ahi_wr  = host_wr && (host_addr == OFF_AHI);
  end

  always_comb begin
    op = '0;
    unique case (mode)
      MODE_B8: begin
        op.fetch  = lane_rd;
        op.commit = lane_wr;
        op.be     = LANES'(1) << lane;
      end
      MODE_H16: begin
        op.fetch    = lane_rd && !lane[0];
        op.commit   = lane_wr && lane[0];
        op.stage_wr = lane_wr;
        op.be       = lane[1] ? 4'hC : 4'h3;
      end
      default: begin
        op.fetch    = lane_rd && (lane == 2'd0);
        op.commit   = lane_wr && (lane == 2'd3);
        op.stage_wr = lane_wr;
        op.be       = '1;
        op.inc      = (mode == MODE_W32INC) &&
                      ((lane_rd && (lane == 2'd0)) || (lane_wr && (lane == 2'd3)));
      end
    endcase
  end

endmodule

// File: rtl/hostwin_addr.sv
module hostwin_addr
  import hostwin_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alo_wr,
  input  logic                 ahi_wr,
  input  logic                 inc,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [ADDR_W-3:0]    word,
  output mode_e                mode,
  output logic [BYTE_W-1:0]    rb_lo,
  output logic [BYTE_W-1:0]    rb_hi
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int HI_W   = ADDR_W - 8;
  localparam int LO_W   = 6;

  logic [WORD_W-1:0] word_q;
  mode_e             mode_q;
  logic              unused_top;

  assign unused_top = ^wdata[BYTE_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      mode_q <= MODE_B8;
    end else if (alo_wr) begin
      word_q[LO_W-1:0] <= wdata[BYTE_W-1:2];
      mode_q           <= mode_e'(wdata[1:0]);
    end else if (ahi_wr) begin
      word_q[WORD_W-1:LO_W] <= wdata[HI_W-1:0];
    end else if (inc) begin
      word_q <= word_q + 1'b1;
    end
  end

  assign word  = word_q;
  assign mode  = mode_q;
  assign rb_lo = {word_q[LO_W-1:0], mode_q};
  assign rb_hi = {{(BYTE_W-HI_W){1'b0}}, word_q[WORD_W-1:LO_W]};

endmodule

// File: rtl/hostwin_stage.sv
module hostwin_stage
  import hostwin_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          load_pend,
  input  logic [LANES-1:0]              load_be,
  input  logic [LANES*BYTE_W-1:0]       mem_rdata,
  input  logic                          stage_wr,
  input  logic [1:0]                    lane,
  input  logic [BYTE_W-1:0]             wdata,
  output logic [LANES-1:0][BYTE_W-1:0]  eff,
  output logic [LANES*BYTE_W-1:0]       commit_word
);

  logic [LANES-1:0][BYTE_W-1:0] stage_q;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic hit;
    assign hit = stage_wr && (lane == 2'(n));
    assign eff[n] = (load_pend && load_be[n]) ?
                    mem_rdata[n*BYTE_W +: BYTE_W] : stage_q[n];
    assign commit_word[n*BYTE_W +: BYTE_W] = hit ? wdata : eff[n];

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        stage_q[n] <= '0;
      end else if (hit) begin
        stage_q[n] <= wdata;
      end else begin
        stage_q[n] <= eff[n];
      end
    end
  end

endmodule

// File: rtl/hostwin_port.sv
module hostwin_port
  import hostwin_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               host_addr,
  input  logic                     host_rd,
  input  logic                     host_wr,
  input  logic [7:0]               host_wdata,
  output logic [7:0]               host_rdata,
  output logic                     host_rvalid,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-3:0]        mem_addr,
  output logic [3:0]               mem_be,
  output logic [31:0]              mem_wdata,
  input  logic [31:0]              mem_rdata
);

  mode_e                        mode;
  logic [ADDR_W-3:0]            word;
  logic [BYTE_W-1:0]            rb_lo;
  logic [BYTE_W-1:0]            rb_hi;
  logic                         rd_act;
  logic                         is_lane;
  logic [1:0]                   lane;
  logic                         alo_wr;
  logic                         ahi_wr;
  mem_op_t                      op;
  logic [LANES-1:0][BYTE_W-1:0] eff;
  logic [LANES*BYTE_W-1:0]      commit_word;

  logic                         rvalid_q;
  logic                         lane_rd_q;
  logic [1:0]                   lane_q;
  logic [BYTE_W-1:0]            rdata_q;
  logic                         load_pend_q;
  logic [LANES-1:0]             load_be_q;

  hostwin_decode u_decode (
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .mode      (mode),
    .rd_act    (rd_act),
    .is_lane   (is_lane),
    .lane      (lane),
    .alo_wr    (alo_wr),
    .ahi_wr    (ahi_wr),
    .op        (op)
  );

  hostwin_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .alo_wr (alo_wr),
    .ahi_wr (ahi_wr),
    .inc    (op.inc),
    .wdata  (host_wdata),
    .word   (word),
    .mode   (mode),
    .rb_lo  (rb_lo),
    .rb_hi  (rb_hi)
  );

  hostwin_stage u_stage (
    .clk         (clk),
    .rst         (rst),
    .clear       (alo_wr || ahi_wr),
    .load_pend   (load_pend_q),
    .load_be     (load_be_q),
    .mem_rdata   (mem_rdata),
    .stage_wr    (op.stage_wr),
    .lane        (lane),
    .wdata       (host_wdata),
    .eff         (eff),
    .commit_word (commit_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q    <= 1'b0;
      lane_rd_q   <= 1'b0;
      lane_q      <= '0;
      rdata_q     <= '0;
      load_pend_q <= 1'b0;
      load_be_q   <= '0;
    end else begin
      rvalid_q    <= rd_act;
      lane_rd_q   <= rd_act && is_lane;
      lane_q      <= lane;
      load_pend_q <= op.fetch;
      load_be_q   <= op.be;
      if (rd_act) begin
        if (host_addr == OFF_ALO)      rdata_q <= rb_lo;
        else if (host_addr == OFF_AHI) rdata_q <= rb_hi;
        else                           rdata_q <= '0;
      end
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = lane_rd_q ? eff[lane_q] : rdata_q;

  assign mem_req   = op.fetch || op.commit;
  assign mem_we    = op.commit;
  assign mem_addr  = word;
  assign mem_be    = op.be;
  assign mem_wdata = (mode == MODE_B8) ? {LANES{host_wdata}} : commit_word;

endmodule

// File: rtl/hostwin_port_chk.sv
module hostwin_port_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              host_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [3:0]        mem_be
);

  logic [1:0]        mode_s;
  logic [ADDR_W-3:0] exp_addr;
  logic              exp_vld;
  logic              unused_wd;

  assign unused_wd = ^host_wdata[7:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_s   <= 2'd0;
      exp_vld  <= 1'b0;
      exp_addr <= '0;
    end else begin
      if (host_wr && host_addr == 3'd0) mode_s <= host_wdata[1:0];
      if (host_wr && host_addr <= 3'd1) begin
        exp_vld <= 1'b0;
      end else if (mem_req && mode_s == 2'd3) begin
        exp_vld  <= 1'b1;
        exp_addr <= mem_addr + 1'b1;
      end
    end
  end

  assert_req_on_lane_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((host_rd || host_wr) && host_addr >= 3'd2 && host_addr <= 3'd5));

  assert_no_upper_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && mode_s[1] && host_addr >= 3'd3 && host_addr <= 3'd5) |-> !mem_req);

  assert_stage_only_R4: assert property (@(posedge clk) disable iff (rst)
    (host_wr && mode_s[1] && host_addr >= 3'd2 && host_addr <= 3'd4) |-> !mem_req);

  assert_full_be_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mode_s[1]) |-> (mem_be == 4'hF));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && exp_vld && mode_s == 2'd3) |-> (mem_addr == exp_addr));

  assert_one_be_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mode_s == 2'd0) |-> $onehot(mem_be));

  assert_half_be_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mode_s == 2'd1) |-> (mem_be == 4'h3 || mem_be == 4'hC));

  assert_hi_top_R2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && host_addr == 3'd1) |=> !host_rdata[7]);

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> host_rvalid);

  assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !(host_rd && !host_wr) |=> !host_rvalid);

  assert_store_is_req_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_req && host_wr));

endmodule

bind hostwin_port hostwin_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_addr   (host_addr),
  .host_rd     (host_rd),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be)
);

// File: tb/hostwin_port_tb.sv
module hostwin_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 15;

  typedef struct packed {
    logic       wr;
    logic [2:0] off;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t VECS [0:NV-1] = '{
    // R1 R3: word mode, no increment, byte address 0x10
    {1'b1,3'd0,8'h12,4'd1}, {1'b1,3'd1,8'h00,4'd2},
    {1'b0,3'd0,8'h12,4'd1}, {1'b0,3'd1,8'h00,4'd2},
    {1'b0,3'd2,8'h4A,4'd3}, {1'b0,3'd3,8'h4B,4'd3},
    {1'b0,3'd4,8'h48,4'd3}, {1'b0,3'd5,8'h49,4'd3},
    {1'b0,3'd2,8'h4A,4'd5}, {1'b0,3'd0,8'h12,4'd5},
    // R5: auto-increment fetches at 0x20
    {1'b1,3'd0,8'h23,4'd1}, {1'b1,3'd1,8'h00,4'd2},
    {1'b0,3'd2,8'h7A,4'd3}, {1'b0,3'd5,8'h79,4'd3},
    {1'b0,3'd0,8'h27,4'd5}, {1'b0,3'd2,8'h7E,4'd5},
    // R4 R5: streamed stores at 0x130 and 0x134
    {1'b1,3'd0,8'h33,4'd1}, {1'b1,3'd1,8'h01,4'd2},
    {1'b1,3'd2,8'h11,4'd4}, {1'b1,3'd3,8'h22,4'd4},
    {1'b1,3'd4,8'h33,4'd4}, {1'b1,3'd5,8'h44,4'd4},
    {1'b1,3'd2,8'h55,4'd4}, {1'b1,3'd3,8'h66,4'd4},
    {1'b1,3'd4,8'h77,4'd4}, {1'b1,3'd5,8'h88,4'd4},
    {1'b0,3'd0,8'h3B,4'd5}, {1'b0,3'd1,8'h01,4'd2},
    {1'b1,3'd0,8'h32,4'd1},
    {1'b0,3'd2,8'h11,4'd4}, {1'b0,3'd5,8'h44,4'd4},
    {1'b1,3'd0,8'h36,4'd1},
    {1'b0,3'd2,8'h55,4'd4}, {1'b0,3'd4,8'h77,4'd4},
    // R2: top bit of the high address byte dropped
    {1'b1,3'd1,8'hFF,4'd2}, {1'b0,3'd1,8'h7F,4'd2},
    {1'b1,3'd1,8'h00,4'd2},
    // R7: byte mode at 0x40
    {1'b1,3'd0,8'h40,4'd1}, {1'b1,3'd4,8'hEE,4'd7},
    {1'b0,3'd4,8'hEE,4'd7}, {1'b0,3'd3,8'h1B,4'd7},
    {1'b0,3'd2,8'h1A,4'd7}, {1'b0,3'd5,8'h19,4'd7},
    {1'b1,3'd0,8'h42,4'd1},
    {1'b0,3'd2,8'h1A,4'd7}, {1'b0,3'd3,8'h1B,4'd7},
    {1'b0,3'd4,8'hEE,4'd7},
    // R8: halfword mode at 0x50
    {1'b1,3'd0,8'h51,4'd1}, {1'b1,3'd4,8'hAB,4'd8},
    {1'b1,3'd5,8'hCD,4'd8}, {1'b0,3'd4,8'hAB,4'd8},
    {1'b0,3'd5,8'hCD,4'd8}, {1'b0,3'd2,8'h0A,4'd8},
    {1'b0,3'd3,8'h0B,4'd8},
    {1'b1,3'd0,8'h52,4'd1},
    {1'b0,3'd2,8'h0A,4'd8}, {1'b0,3'd3,8'h0B,4'd8},
    {1'b0,3'd4,8'hAB,4'd8}, {1'b0,3'd5,8'hCD,4'd8},
    {1'b0,3'd0,8'h52,4'd1}, {1'b0,3'd1,8'h00,4'd2},
    {1'b0,3'd0,8'h52,4'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        mem_req;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int errors = 0;
  int checks = 0;
  int req_cnt = 0;
  int st_cnt = 0;

  logic [31:0] ram [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  hostwin_port #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_word(input int i);
    logic [31:0] w;
    for (int n = 0; n < 4; n++) w[n*8 +: 8] = 8'(4*i + n) ^ 8'h5A;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) ram[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int n = 0; n < 4; n++)
          if (mem_be[n]) ram[mem_addr[7:0]][n*8 +: 8] <= mem_wdata[n*8 +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[7:0]];
      end
    end
    if (!rst && mem_req) req_cnt <= req_cnt + 1;
    if (!rst && mem_we)  st_cnt  <= st_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    host_addr = off; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] off, output logic [7:0] d, output logic v);
    @(negedge clk);
    host_addr = off; host_rd = 1'b1;
    @(negedge clk);
    d = host_rdata; v = host_rvalid; host_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic       v;
    int         base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 rvalid idle after reset", 32'(host_rvalid), 32'd0);
    do_rd(3'd0, d, v);
    check("R10 low address after reset", 32'(d), 32'h00);
    check("R10 rvalid on read", 32'(v), 32'd1);
    do_rd(3'd1, d, v);
    check("R10 high address after reset", 32'(d), 32'h00);
    @(negedge clk);
    check("R10 rvalid drops", 32'(host_rvalid), 32'd0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) begin
        do_wr(VECS[k].off, VECS[k].data);
      end else begin
        do_rd(VECS[k].off, d, v);
        check($sformatf("R%0d vector %0d data", VECS[k].req, k), 32'(d), 32'(VECS[k].data));
        check($sformatf("R%0d vector %0d rvalid", VECS[k].req, k), 32'(v), 32'd1);
      end
    end

    // R3: upper lanes read without any memory access
    do_wr(3'd0, 8'h12);
    do_wr(3'd1, 8'h00);
    base = req_cnt;
    do_rd(3'd3, d, v);
    do_rd(3'd4, d, v);
    do_rd(3'd5, d, v);
    check("R3 no fetch on upper lanes", 32'(req_cnt - base), 32'd0);
    do_rd(3'd2, d, v);
    check("R3 one fetch on lane 0", 32'(req_cnt - base), 32'd1);

    // R9: address write clears staged bytes
    do_wr(3'd0, 8'h62);
    base = st_cnt;
    do_wr(3'd2, 8'h01);
    do_wr(3'd3, 8'h02);
    do_wr(3'd4, 8'h03);
    check("R4 no store before lane 3", 32'(st_cnt - base), 32'd0);
    do_wr(3'd1, 8'h00);
    do_wr(3'd5, 8'h04);
    check("R4 one store on lane 3", 32'(st_cnt - base), 32'd1);
    do_rd(3'd2, d, v);
    check("R9 cleared lane 0", 32'(d), 32'h00);
    do_rd(3'd4, d, v);
    check("R9 cleared lane 2", 32'(d), 32'h00);
    do_rd(3'd5, d, v);
    check("R9 new lane 3", 32'(d), 32'h04);

    // R4: misaligned start at lane 2
    do_wr(3'd0, 8'h72);
    do_wr(3'd4, 8'h5C);
    do_wr(3'd5, 8'h5D);
    do_rd(3'd2, d, v);
    check("R4 partial store lane 0", 32'(d), 32'h00);
    do_rd(3'd4, d, v);
    check("R4 partial store lane 2", 32'(d), 32'h5C);
    do_rd(3'd5, d, v);
    check("R4 partial store lane 3", 32'(d), 32'h5D);

    // R6: wrap at the top of the address space
    do_wr(3'd0, 8'hFF);
    do_wr(3'd1, 8'h7F);
    do_rd(3'd2, d, v);
    check("R6 fetch at top word", 32'(d), 32'hA6);
    do_rd(3'd0, d, v);
    check("R6 low address wrapped", 32'(d), 32'h03);
    do_rd(3'd1, d, v);
    check("R6 high address wrapped", 32'(d), 32'h00);

    finish_run();
  end

endmodule